// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned W-bit integer by another over many clock cycles and returns a W-bit quotient and a W-bit remainder. It is built for a datapath where division is rare, so it uses one shared shift register and one narrow adder/subtractor instead of a wide combinational array. A caller pulses `start` with the operands applied. The block then runs on its own until it raises `done` for one cycle. The results stay on the outputs until the next accepted `start`.

Internally there is one working register that is two operand widths plus one bit wide. The lower W bits begin as the dividend and fill up with quotient bits from the right. The upper W+1 bits hold the partial remainder. The spare top bit lets a partial remainder of up to twice the divisor exist without loss, and this is what makes divisors with the MSB set divide correctly. The dividend is shifted left once as it is loaded, so no wasted first subtraction is made. Each quotient bit is settled in one of two ways:
- A trial subtraction that gives no borrow keeps the difference and shifts in a 1. This takes one cycle.
- A trial subtraction that borrows is followed by a cycle that adds the divisor back and shifts in a 0.

A final cycle moves the remainder half right by one place to undo the surplus shift.

A zero divisor needs no special path. The loop produces an all-ones quotient and returns the dividend as the remainder, and a flag reports the case.

Top module: `seq_restoring_div`

## Requirements
- R1: After reset, `done`, `busy` and `div_by_zero` are 0 and `quotient` and `remainder` read 0.
- R2: For a nonzero divisor, the `quotient` and `remainder` read while `done` is high satisfy dividend = quotient*divisor + remainder, with remainder < divisor. For example, 74 / 8 gives quotient 9 and remainder 2.
- R3: R2 also holds when the divisor has its most significant bit set, and when the dividend is smaller than the divisor (quotient 0, remainder equal to the dividend).
- R4: For a zero divisor, the block returns a quotient of all ones and a remainder equal to the dividend, and `div_by_zero` is 1 while those results are presented. For a nonzero divisor, `div_by_zero` is 0.
- R5: `done` is high for exactly one cycle per operation. `busy` is high from the first cycle after `start` is accepted until the cycle in which `done` rises, and `busy` is never high together with `done`. `quotient`, `remainder` and `div_by_zero` hold their values while the block is idle.
- R6: A `start` pulse that arrives while `busy` is high is ignored. The operation in progress completes with its original operands.
- R7: `done` is first seen high after exactly W + Z + 1 rising edges that follow the edge at which `start` was accepted. Z is the number of 0 bits in the W-bit quotient: one cycle per 1 bit, two cycles per 0 bit, and one correction cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a division; sampled only while idle |
| dividend | input | W | Unsigned dividend, captured with `start` |
| divisor | input | W | Unsigned divisor, captured with `start` |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse; results are valid from here on |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |
| div_by_zero | output | 1 | The last accepted divisor was zero |

## Verification
The bench targets divisors with the top bit set. If the spare remainder bit were missing, these would return a wrong quotient, because the shifted partial remainder would overflow. It also tries a dividend below the divisor, which drives every quotient bit through the restore path. A missed restore, or a 1 shifted in where a 0 belongs, would show up there as a wrong quotient or remainder and as a wrong cycle count. A zero divisor, a divisor of one, equal operands and all-ones operands test the edges of the loop count and of the final right shift. A forgotten correction would leave the remainder doubled. A `start` pulse injected in the middle of a run checks that the design does not reload, since a reload would show up as a result for the wrong operands.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SUB     = 2'd1,
    ST_RESTORE = 2'd2,
    ST_FIN     = 2'd3
  } div_state_e;
endpackage

// File: rtl/div_rst_sync.sv
module div_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/div_addsub.sv
// Adds or subtracts the W-bit divisor to or from the (W+1)-bit partial
// remainder; the borrow is taken one bit above the stored width.
module div_addsub #(
  parameter int W = 32
) (
  input  logic [W:0]   opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  output logic [W:0]   res,
  output logic         borrow
);
  localparam int XW = W + 2;

  logic [XW-1:0] ext_a, ext_b, sum;

  assign ext_a  = {1'b0, opa};
  assign ext_b  = {2'b00, opb};
  assign sum    = sub ? (ext_a - ext_b) : (ext_a + ext_b);
  assign res    = sum[W:0];
  assign borrow = sub & sum[XW-1];
endmodule

// File: rtl/div_bit_counter.sv
module div_bit_counter #(
  parameter int W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  output logic                    last,
  output logic [$clog2(W+1)-1:0]  count
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | step;
    if (load) cnt_d = CW'(W);
    else      cnt_d = count - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_d;
  end

  assign last = (count == CW'(1));

  p_step_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (count != '0));
  p_load_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == CW'(W)));
endmodule

// File: rtl/seq_restoring_div.sv
module seq_restoring_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  import div_pkg::*;

  localparam int RW = 2 * W + 1;
  localparam int CW = $clog2(W + 1);

  logic             rst_s_n;
  div_state_e       st_q, st_d;
  logic [RW-1:0]    rem_q, rem_d;
  logic [W-1:0]     dvs_q;
  logic             err_q, err_d;
  logic             done_q;
  logic             rem_en, dvs_en;
  logic [W:0]       hi;
  logic [W-1:0]     lo;
  logic [W:0]       as_res;
  logic             as_sub, as_borrow;
  logic [RW-1:0]    joined;
  logic             cnt_load, cnt_step, cnt_last;
  logic [CW-1:0]    cnt_val;

  div_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s_n)
  );

  assign hi     = rem_q[RW-1:W];
  assign lo     = rem_q[W-1:0];
  assign joined = {as_res, lo};
  assign as_sub = (st_q == ST_SUB);

  div_addsub #(.W(W)) u_addsub (
    .opa    (hi),
    .opb    (dvs_q),
    .sub    (as_sub),
    .res    (as_res),
    .borrow (as_borrow)
  );

  div_bit_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .load  (cnt_load),
    .step  (cnt_step),
    .last  (cnt_last),
    .count (cnt_val)
  );

  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    err_d    = err_q;
    rem_en   = 1'b0;
    dvs_en   = 1'b0;
    cnt_load = 1'b0;
    cnt_step = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          rem_d    = {{W{1'b0}}, dividend, 1'b0};
          err_d    = (divisor == '0);
          rem_en   = 1'b1;
          dvs_en   = 1'b1;
          cnt_load = 1'b1;
          st_d     = ST_SUB;
        end
      end
      ST_SUB: begin
        rem_en = 1'b1;
        if (as_borrow) begin
          rem_d = joined;
          st_d  = ST_RESTORE;
        end else begin
          rem_d    = {joined[RW-2:0], 1'b1};
          cnt_step = 1'b1;
          st_d     = cnt_last ? ST_FIN : ST_SUB;
        end
      end
      ST_RESTORE: begin
        rem_en   = 1'b1;
        rem_d    = {joined[RW-2:0], 1'b0};
        cnt_step = 1'b1;
        st_d     = cnt_last ? ST_FIN : ST_SUB;
      end
      ST_FIN: begin
        rem_en = 1'b1;
        rem_d  = {1'b0, hi[W:1], lo};
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      dvs_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_FIN);
      if (rem_en) rem_q <= rem_d;
      if (dvs_en) begin
        dvs_q <= divisor;
        err_q <= err_d;
      end
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign quotient    = rem_q[W-1:0];
  assign remainder   = rem_q[2*W-1:W];
  assign div_by_zero = err_q;

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);
  p_busy_quiet_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> !busy);
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && !div_by_zero) |-> (remainder < dvs_q));
  p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && div_by_zero) |-> (quotient == {W{1'b1}}));
  p_restore_bound_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_RESTORE) |-> (as_res < {dvs_q, 1'b0}));
endmodule

// File: tb/seq_restoring_div_test.sv
`timescale 1ns/1ps
module seq_restoring_div_test;
  localparam int W = 32;
  localparam int WATCHDOG = 200000;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] dividend, divisor;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int checks;
  int failures;
  int cyc;

  seq_restoring_div #(.W(W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WATCHDOG) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [W-1:0] exp_q(input logic [W-1:0] a, input logic [W-1:0] b);
    return (b == '0) ? {W{1'b1}} : a / b;
  endfunction

  function automatic logic [W-1:0] exp_r(input logic [W-1:0] a, input logic [W-1:0] b);
    return (b == '0) ? a : a % b;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                         input string req, input bit inject);
    logic [W-1:0] eq, er;
    int n;
    int zeros;
    int exp_cyc;
    eq = exp_q(a, b);
    er = exp_r(a, b);
    zeros = W - $countones(eq);
    exp_cyc = W + zeros + 1;
    @(negedge clk);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R5", "busy after start", W'(busy), W'(1));
    n = 0;
    while (!done && n < 3 * W + 10) begin
      @(posedge clk);
      n = n + 1;
      @(negedge clk);
      if (inject && n == 5) begin
        start    = 1'b1;
        dividend = ~a;
        divisor  = b ^ 32'h0000_0013;
      end else if (inject && n == 6) begin
        start = 1'b0;
      end
    end
    check(done == 1'b1, req, "done seen", W'(done), W'(1));
    check(busy == 1'b0, "R5", "busy low with done", W'(busy), W'(0));
    check(quotient == eq, req, "quotient", quotient, eq);
    check(remainder == er, req, "remainder", remainder, er);
    check(div_by_zero == (b == '0), "R4", "zero-divisor flag", W'(div_by_zero), W'(b == '0));
    check(n == exp_cyc, "R7", "latency", W'(n), W'(exp_cyc));
    @(negedge clk);
    check(done == 1'b0, "R5", "done single pulse", W'(done), W'(0));
    repeat (3) @(negedge clk);
    check(quotient == eq && remainder == er, "R5", "results held idle", quotient, eq);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    cyc      = 0;
    rst_n    = 1'b0;
    start    = 1'b0;
    dividend = '0;
    divisor  = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0 && busy == 1'b0, "R1", "control after reset", W'({done, busy}), W'(0));
    check(quotient == '0 && remainder == '0, "R1", "results after reset", quotient | remainder, W'(0));
    check(div_by_zero == 1'b0, "R1", "flag after reset", W'(div_by_zero), W'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1", "idle after release", W'({done, busy}), W'(0));

    // R2 directed
    run_div(32'd74, 32'd8, "R2", 1'b0);
    run_div(32'd100, 32'd7, "R2", 1'b0);
    run_div(32'hFFFF_FFFF, 32'd1, "R2", 1'b0);
    run_div(32'd12345, 32'd12345, "R2", 1'b0);
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2", 1'b0);
    // R3 divisor MSB set and dividend below divisor
    run_div(32'hFFFF_FFFF, 32'h8000_0001, "R3", 1'b0);
    run_div(32'hF000_0000, 32'h8000_0000, "R3", 1'b0);
    run_div(32'h7FFF_FFFF, 32'h8000_0000, "R3", 1'b0);
    run_div(32'd5, 32'd9, "R3", 1'b0);
    run_div(32'd0, 32'd3, "R3", 1'b0);
    // R4 zero divisor
    run_div(32'hDEAD_BEEF, 32'd0, "R4", 1'b0);
    run_div(32'd0, 32'd0, "R4", 1'b0);
    // R6 start ignored while busy
    run_div(32'd987654321, 32'd1234, "R6", 1'b1);
    run_div(32'h9000_0000, 32'h8765_4321, "R6", 1'b1);

    // R2 random mix
    for (int i = 0; i < 48; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom >> ($urandom % 32);
      if (i % 8 == 7) rb = rb | 32'h8000_0000;
      run_div(ra, rb, (rb[W-1] ? "R3" : "R2"), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule